// File: doc/BRIEF.md
# Page Table Walker

This block resolves a translation-buffer miss by fetching one entry from a single-level page table that sits in ordinary memory. The requester presents the missing virtual address, whether the access was a load or a store, and the base address of the table. The walker computes the entry's address from the base and the virtual page number and reads that word through a request/ready memory port. It then inspects the entry's valid bit.

A valid entry produces a one-cycle refill pulse carrying the virtual page number, the physical page number and the dirty state, so the translation buffer can be refilled and the access retried. An invalid entry is a true page fault rather than a plain translation miss. The walker then pulses a fault output, captures the complete faulting virtual address in a held register and reports a cause code that tells loads from stores.

The walker also maintains the entry's usage bits in memory. Every access marks the page referenced, and every store marks it dirty. The updated word is written back only when one of those bits actually goes from 0 to 1. The walker serves one miss at a time.

Top module: `pgwalk_top`

## Requirements
- R1: While reset is high and after it is released, the walker is idle: `miss_ready` is 1, `mem_req`, `refill_valid` and `fault_valid` are 0, and `fault_addr` and `fault_cause` are 0.
- R2: Each walk issues exactly one read. The read address is `table_base + 4 * VPN`, where VPN is `miss_vaddr[31:12]`. The request, its address and its write flag stay unchanged until `mem_ready` is 1.
- R3: The page-table entry is one 32-bit word with this layout: valid in bit 0, referenced in bit 1, dirty in bit 2, physical page number in bits 31:12. When the entry is valid, `refill_valid` is 1 for exactly one cycle. In that cycle `refill_vpn` equals the VPN, `refill_ppn` equals entry bits 31:12, and `refill_dirty` equals the entry's dirty bit after any update.
- R4: When the entry's valid bit is 0, `fault_valid` is 1 for exactly one cycle, no refill occurs and no memory write is issued. `fault_cause` is 1 for a load and 2 for a store.
- R5: On a fault, `fault_addr` takes the complete 32-bit `miss_vaddr` of that walk. It keeps that value through later successful walks until the next fault.
- R6: A valid entry is written back to the same address when its referenced bit is 0, or when the access is a store and its dirty bit is 0. The written word is the read word with the referenced bit set, and with the dirty bit also set for a store.
- R7: No memory write is issued for a valid entry whose referenced bit is already 1 and that needs no dirty change, meaning a load, or a store to an entry that is already dirty. The table word stays unchanged.
- R8: `miss_ready` falls in the cycle after a miss is accepted and rises again in the cycle after the refill or fault pulse. While it is low, `miss_valid` and `miss_vaddr` are ignored.
- R9: Read data is taken from `mem_rdata` in the cycle after the cycle in which `mem_ready` was 1 for the read. It is not taken in any other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A translation miss is offered |
| miss_ready | output | 1 | Walker is idle and accepts a miss |
| miss_vaddr | input | 32 | Full virtual address that missed |
| miss_store | input | 1 | 1 if the missing access is a store |
| table_base | input | 32 | Start address of the page table |
| mem_req | output | 1 | Memory request, held until ready |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_ready | input | 1 | Memory accepts the current request |
| mem_rdata | input | 32 | Read data, valid the cycle after ready |
| refill_valid | output | 1 | One-cycle translation refill pulse |
| refill_vpn | output | 20 | Virtual page number being refilled |
| refill_ppn | output | 20 | Physical page number from the entry |
| refill_dirty | output | 1 | Dirty state of the refilled page |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_addr | output | 32 | Virtual address of the last fault |
| fault_cause | output | 2 | 1 load fault, 2 store fault |

## Verification
Directed entries cover each usage-bit combination against both access kinds:
- a referenced bit that is clear;
- an entry that is referenced but clean, hit by a load and by a store;
- an entry that is fully marked, hit by a store.

Together these separate the write-back case from the skipped write.

Invalid entries are walked with a load and with a store, which tells the two cause codes apart. A later valid walk shows that the fault address is held.

Other directed cases cover:
- a change of table base;
- the largest page number, which exercises the address arithmetic;
- a second miss presented while a walk is busy, which shows that it is ignored.

Random entries and addresses, served with random memory latency and with junk on the read bus outside the data cycle, show that the entry is taken in the right cycle. They also check that refill contents follow the entry word for arbitrary bit patterns.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_CHECK   = 3'd3,
    ST_WB      = 3'd4,
    ST_DONE    = 3'd5,
    ST_FAULT   = 3'd6
  } walk_state_t;

  localparam int PTE_V_BIT = 0;
  localparam int PTE_R_BIT = 1;
  localparam int PTE_D_BIT = 2;

  localparam logic [1:0] CAUSE_NONE  = 2'd0;
  localparam logic [1:0] CAUSE_LOAD  = 2'd1;
  localparam logic [1:0] CAUSE_STORE = 2'd2;

endpackage

// File: rtl/pgw_addr_gen.sv
module pgw_addr_gen #(
  parameter int ADDR_W    = 32,
  parameter int VPN_W     = 20,
  parameter int PTE_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [VPN_W-1:0]  vpn,
  output logic [ADDR_W-1:0] entry_addr
);
  localparam int SHIFT = $clog2(PTE_BYTES);

  logic [ADDR_W-1:0] offset;

  generate
    if (SHIFT == 0) begin : g_noshift
      assign offset = ADDR_W'(vpn);
    end else begin : g_shift
      assign offset = ADDR_W'(vpn) << SHIFT;
    end
  endgenerate

  assign entry_addr = base + offset;
endmodule

// File: rtl/pgw_pte_update.sv
module pgw_pte_update
  import pgw_pkg::*;
#(
  parameter int PTE_W = 32
) (
  input  logic [PTE_W-1:0] pte_in,
  input  logic             is_store,
  output logic [PTE_W-1:0] pte_out,
  output logic             pte_valid,
  output logic             need_wb
);
  always_comb begin
    pte_out            = pte_in;
    pte_out[PTE_R_BIT] = 1'b1;
    if (is_store) begin
      pte_out[PTE_D_BIT] = 1'b1;
    end
  end

  assign pte_valid = pte_in[PTE_V_BIT];
  assign need_wb   = pte_valid &&
                     (!pte_in[PTE_R_BIT] || (is_store && !pte_in[PTE_D_BIT]));
endmodule

// File: rtl/pgw_walk_fsm.sv
module pgw_walk_fsm
  import pgw_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int ADDR_W = 32,
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 20
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   miss_valid,
  output logic                   miss_ready,
  input  logic [VA_W-1:0]        miss_vaddr,
  input  logic                   miss_store,
  input  logic [ADDR_W-1:0]      entry_addr,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [PTE_W-1:0]       mem_wdata,
  input  logic                   mem_ready,
  input  logic [PTE_W-1:0]       mem_rdata,
  output logic [PTE_W-1:0]       pte_cur,
  output logic                   store_cur,
  input  logic [PTE_W-1:0]       upd_pte,
  input  logic                   upd_valid,
  input  logic                   upd_need_wb,
  output logic                   refill_valid,
  output logic [VA_W-OFF_W-1:0]  refill_vpn,
  output logic [PPN_W-1:0]       refill_ppn,
  output logic                   refill_dirty,
  output logic                   fault_valid,
  output logic [VA_W-1:0]        fault_addr,
  output logic [1:0]             fault_cause
);
  walk_state_t       state;
  logic [VA_W-1:0]   va_q;
  logic              store_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PTE_W-1:0]  pte_q;
  logic [VA_W-1:0]   fault_addr_q;
  logic [1:0]        cause_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      store_q      <= 1'b0;
      addr_q       <= '0;
      pte_q        <= '0;
      fault_addr_q <= '0;
      cause_q      <= CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (miss_valid) begin
            va_q    <= miss_vaddr;
            store_q <= miss_store;
            addr_q  <= entry_addr;
            state   <= ST_RD_REQ;
          end
        end
        ST_RD_REQ: begin
          if (mem_ready) state <= ST_RD_WAIT;
        end
        ST_RD_WAIT: begin
          pte_q <= mem_rdata;
          state <= ST_CHECK;
        end
        ST_CHECK: begin
          if (!upd_valid) begin
            fault_addr_q <= va_q;
            cause_q      <= store_q ? CAUSE_STORE : CAUSE_LOAD;
            state        <= ST_FAULT;
          end else begin
            pte_q <= upd_pte;
            state <= upd_need_wb ? ST_WB : ST_DONE;
          end
        end
        ST_WB: begin
          if (mem_ready) state <= ST_DONE;
        end
        ST_DONE:  state <= ST_IDLE;
        ST_FAULT: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign miss_ready   = (state == ST_IDLE);
  assign mem_req      = (state == ST_RD_REQ) || (state == ST_WB);
  assign mem_we       = (state == ST_WB);
  assign mem_addr     = addr_q;
  assign mem_wdata    = pte_q;
  assign pte_cur      = pte_q;
  assign store_cur    = store_q;
  assign refill_valid = (state == ST_DONE);
  assign refill_vpn   = va_q[VA_W-1:OFF_W];
  assign refill_ppn   = pte_q[PTE_W-1 -: PPN_W];
  assign refill_dirty = pte_q[PTE_D_BIT];
  assign fault_valid  = (state == ST_FAULT);
  assign fault_addr   = fault_addr_q;
  assign fault_cause  = cause_q;

  // R2: a pending request is held with stable address and direction
  a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: refill is a single-cycle pulse followed by idle
  a_r3_refill_pulse: assert property (@(posedge clk) disable iff (rst)
    refill_valid |=> (!refill_valid && miss_ready));

  // R4: a fault never coincides with a refill or a memory access
  a_r4_fault_alone: assert property (@(posedge clk) disable iff (rst)
    fault_valid |-> (!refill_valid && !mem_req));

  // R5: the recorded fault address changes only with a fault pulse
  a_r5_fault_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_addr) |-> fault_valid);

  // R6: any write-back carries a valid, referenced entry
  a_r6_wb_marks_ref: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (mem_wdata[PTE_R_BIT] && mem_wdata[PTE_V_BIT]));

  // R8: an accepted miss makes the walker busy
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_ready) |=> !miss_ready);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int OFF_W     = 12,
  parameter int ADDR_W    = 32,
  parameter int PTE_W     = 32,
  parameter int PPN_W     = 20,
  parameter int PTE_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  miss_valid,
  output logic                  miss_ready,
  input  logic [VA_W-1:0]       miss_vaddr,
  input  logic                  miss_store,
  input  logic [ADDR_W-1:0]     table_base,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [PTE_W-1:0]      mem_wdata,
  input  logic                  mem_ready,
  input  logic [PTE_W-1:0]      mem_rdata,
  output logic                  refill_valid,
  output logic [VA_W-OFF_W-1:0] refill_vpn,
  output logic [PPN_W-1:0]      refill_ppn,
  output logic                  refill_dirty,
  output logic                  fault_valid,
  output logic [VA_W-1:0]       fault_addr,
  output logic [1:0]            fault_cause
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [ADDR_W-1:0] entry_addr;
  logic [PTE_W-1:0]  pte_cur;
  logic              store_cur;
  logic [PTE_W-1:0]  upd_pte;
  logic              upd_valid;
  logic              upd_need_wb;

  pgw_addr_gen #(
    .ADDR_W(ADDR_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)
  ) addr_i (
    .base(table_base),
    .vpn(miss_vaddr[VA_W-1:OFF_W]),
    .entry_addr(entry_addr)
  );

  pgw_pte_update #(.PTE_W(PTE_W)) upd_i (
    .pte_in(pte_cur),
    .is_store(store_cur),
    .pte_out(upd_pte),
    .pte_valid(upd_valid),
    .need_wb(upd_need_wb)
  );

  pgw_walk_fsm #(
    .VA_W(VA_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W), .PTE_W(PTE_W), .PPN_W(PPN_W)
  ) fsm_i (
    .clk(clk),
    .rst(rst),
    .miss_valid(miss_valid),
    .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr),
    .miss_store(miss_store),
    .entry_addr(entry_addr),
    .mem_req(mem_req),
    .mem_we(mem_we),
    .mem_addr(mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ready(mem_ready),
    .mem_rdata(mem_rdata),
    .pte_cur(pte_cur),
    .store_cur(store_cur),
    .upd_pte(upd_pte),
    .upd_valid(upd_valid),
    .upd_need_wb(upd_need_wb),
    .refill_valid(refill_valid),
    .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn),
    .refill_dirty(refill_dirty),
    .fault_valid(fault_valid),
    .fault_addr(fault_addr),
    .fault_cause(fault_cause)
  );
endmodule

// File: tb/pgwalk_top_tb_top.sv
module pgwalk_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        miss_valid;
  logic        miss_ready;
  logic [31:0] miss_vaddr;
  logic        miss_store;
  logic [31:0] table_base;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ready;
  logic [31:0] mem_rdata;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [19:0] refill_ppn;
  logic        refill_dirty;
  logic        fault_valid;
  logic [31:0] fault_addr;
  logic [1:0]  fault_cause;

  always #5 clk = ~clk;

  pgwalk_top dut_i (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_vaddr(miss_vaddr), .miss_store(miss_store),
    .table_base(table_base),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_dirty(refill_dirty),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_cause(fault_cause)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] pt_mem [0:63];
  logic [31:0] base_r;

  // memory model: random latency, junk on read bus except in data cycle
  int unsigned lat = 0;
  logic        hs_we;
  logic [31:0] hs_addr, hs_wdata;
  logic [5:0]  hs_idx;
  int          rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr, last_wr_addr;

  always @(negedge clk) begin
    mem_rdata = $urandom;
    if (rst) begin
      mem_ready = 1'b0;
      lat = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      hs_idx = 6'((hs_addr - base_r) >> 2);
      if (hs_we) begin
        pt_mem[hs_idx] = hs_wdata;
        wr_cnt++;
        last_wr_addr = hs_addr;
      end else begin
        mem_rdata = pt_mem[hs_idx];
        rd_cnt++;
        last_rd_addr = hs_addr;
      end
    end else if (mem_req) begin
      if (lat == 0) begin
        mem_ready = 1'b1;
        hs_we = mem_we;
        hs_addr = mem_addr;
        hs_wdata = mem_wdata;
        lat = $urandom % 3;
      end else begin
        lat--;
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_update(input logic [31:0] pte, input bit st);
    logic [31:0] n;
    n = pte | 32'h2;
    if (st) n = n | 32'h4;
    return n;
  endfunction

  // one walk; starts and ends just after a falling edge
  task automatic walk(input logic [31:0] va, input bit st, input bit poke);
    logic [19:0] vpn;
    logic [5:0]  idx;
    logic [31:0] pte0, pnew, fa0;
    int rd0, wr0, cyc;
    bit need_wb;
    vpn  = va[31:12];
    idx  = vpn[5:0];
    pte0 = pt_mem[idx];
    rd0  = rd_cnt;
    wr0  = wr_cnt;
    fa0  = fault_addr;
    miss_vaddr = va;
    miss_store = st;
    miss_valid = 1'b1;
    @(negedge clk);
    chk("R8 busy after accept", 64'(miss_ready), 64'd0);
    if (poke) begin
      miss_vaddr = va ^ 32'h0005_5000;
      miss_store = ~st;
    end else begin
      miss_valid = 1'b0;
    end
    cyc = 0;
    while (!(refill_valid || fault_valid) && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    miss_valid = 1'b0;
    pnew = exp_update(pte0, st);
    need_wb = pte0[0] && (pnew != pte0);
    if (pte0[0]) begin
      chk("R3 refill pulse", 64'(refill_valid), 64'd1);
      chk("R4 no fault on valid", 64'(fault_valid), 64'd0);
      chk("R3 refill vpn", 64'(refill_vpn), 64'(vpn));
      chk("R3 refill ppn", 64'(refill_ppn), 64'(pte0[31:12]));
      chk("R3 refill dirty", 64'(refill_dirty), 64'(pnew[2]));
      chk("R5 fault addr held", 64'(fault_addr), 64'(fa0));
    end else begin
      chk("R4 fault pulse", 64'(fault_valid), 64'd1);
      chk("R4 no refill on fault", 64'(refill_valid), 64'd0);
      chk("R4 cause", 64'(fault_cause), st ? 64'd2 : 64'd1);
      chk("R5 fault addr", 64'(fault_addr), 64'(va));
    end
    @(negedge clk);
    chk("R8 idle after result", 64'(miss_ready), 64'd1);
    chk("R3 R4 single-cycle result", 64'(refill_valid | fault_valid), 64'd0);
    chk("R2 one read per walk", 64'(rd_cnt - rd0), 64'd1);
    chk("R2 entry address", 64'(last_rd_addr), 64'(base_r + {10'd0, vpn, 2'b00}));
    if (need_wb) begin
      chk("R6 write-back issued", 64'(wr_cnt - wr0), 64'd1);
      chk("R6 write-back address", 64'(last_wr_addr), 64'(last_rd_addr));
      chk("R6 updated entry", 64'(pt_mem[idx]), 64'(pnew));
    end else begin
      chk("R7 R4 no write", 64'(wr_cnt - wr0), 64'd0);
      chk("R7 entry unchanged", 64'(pt_mem[idx]), 64'(pte0));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    miss_valid = 1'b0;
    miss_vaddr = '0;
    miss_store = 1'b0;
    mem_ready = 1'b0;
    mem_rdata = '0;
    base_r = 32'h0004_0000;
    table_base = base_r;
    for (int i = 0; i < 64; i++) pt_mem[i] = $urandom;
    repeat (3) @(negedge clk);
    chk("R1 reset ready", 64'(miss_ready), 64'd1);
    chk("R1 reset no req", 64'(mem_req), 64'd0);
    chk("R1 reset no refill", 64'(refill_valid), 64'd0);
    chk("R1 reset no fault", 64'(fault_valid), 64'd0);
    chk("R1 reset fault addr", 64'(fault_addr), 64'd0);
    chk("R1 reset cause", 64'(fault_cause), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", 64'(miss_ready), 64'd1);

    // R6: referenced clear, load
    pt_mem[3] = 32'h1234_5001;
    walk(32'h0000_3ABC, 1'b0, 1'b0);
    // R7: referenced set, load
    pt_mem[4] = 32'hABCD_E003;
    walk(32'h0000_4010, 1'b0, 1'b0);
    // R6: clean page, store
    pt_mem[5] = 32'h0F0F_0003;
    walk(32'h0000_5FFC, 1'b1, 1'b0);
    // R7: dirty page, store
    pt_mem[6] = 32'h7777_7007;
    walk(32'h0000_6004, 1'b1, 1'b0);
    // R4: invalid, load then store
    pt_mem[7] = 32'hFFFF_F006;
    walk(32'h0000_7123, 1'b0, 1'b0);
    pt_mem[8] = 32'h1111_1000;
    walk(32'h0000_8456, 1'b1, 1'b0);
    // R5: valid walk after fault keeps fault address
    pt_mem[9] = 32'h2222_2001;
    walk(32'h0000_9000, 1'b0, 1'b0);
    // R8: second miss presented while busy is ignored
    pt_mem[10] = 32'h3333_3001;
    walk(32'h0000_A777, 1'b0, 1'b1);
    // R2: new base and largest page number
    base_r = 32'h0008_0100;
    table_base = base_r;
    pt_mem[63] = 32'h4444_4005;
    walk(32'hFFFF_FFFF, 1'b1, 1'b0);
    pt_mem[1] = 32'h5555_5001;
    walk(32'h0000_1000, 1'b1, 1'b0);

    // R9 and general: random entries, addresses and access kinds
    for (int n = 0; n < 60; n++) begin
      logic [31:0] va;
      va = $urandom;
      pt_mem[va[17:12]] = $urandom;
      walk(va, 1'($urandom), 1'($urandom % 8 == 0));
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule